// File: doc/BRIEF.md
# Bit-Serial Priority Contention Unit for a Shared Parallel Bus

Each board that wants temporary mastership of a shared parallel bus has one copy of this unit. The board's priority code comes from static local switches and has `PRIO_W` bits. The unit contends for the bus over `PRIO_W` shared active-low open-collector priority lines. While the board's request is active, the unit pulls low the lines where its code holds a 1. The most significant line is decided first.

At each lower bit the unit stays in the contest only if no higher-priority contender has shown itself. A higher contender shows itself as an asserted line where this board's own code bit is 0. Once the unit loses at some bit, it releases every line below that bit. When all boards on the bus settle, only the requester or requesters with the highest code still see themselves in contention after bit 0.

The contention chain is purely combinational. A settle counter waits until the request has been stable for `SETTLE_CYC` clocks and only then samples the chain's verdict into a registered win flag. This gives the ripple across boards time to resolve. The win output is gated off at once when the request drops or reset is active.

Top module: `prio_contender`

## Requirements
- R1: The unit has `PRIO_W` (default 4) priority lines, read at `line_n_i`, where 0 means asserted. A 1 on `pull_o[n]` means this board pulls line n low. Index `PRIO_W-1` is the most significant bit and is decided first.
- R2: The most significant line is pulled exactly when the request is active and the matching code bit is 1.
- R3: With the request inactive, no line is pulled.
- R4: If line k is asserted while the board's code bit k is 0, the board pulls none of the lines below k.
- R5: A board that has matched every asserted line above bit n pulls line n exactly when its code bit n is 1.
- R6: When several boards with distinct codes request on one line set, only the board with the numerically highest code raises `win_o`, and every asserted line corresponds to a 1 in that winner's code.
- R7: A lone requester wins whatever its code, including code 0.
- R8: `win_o` rises only at the (`SETTLE_CYC`+1)-th rising clock edge with the request held high, and not earlier.
- R9: `win_o` is 0 in the same cycle the request goes low, and it is 0 while the synchronous reset is held.
- R10: Requesters with equal highest codes all raise `win_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Local arbitration request |
| code_i | input | PRIO_W | Static priority switches |
| line_n_i | input | PRIO_W | Sensed bus priority lines, active low |
| pull_o | output | PRIO_W | Open-collector drive enables, 1 pulls the line low |
| win_o | output | 1 | This board holds the highest request |

## Verification
The bench targets three kinds of error: codes that differ only in a low bit, a loser that keeps driving its low bits after losing at a high bit, and a requester with code 0. With the last, a chain that wrongly tests its own switch bit would never win alone, and a chain that forgets to withdraw would let two boards both claim the bus. The settle window is probed one edge before and one edge at the expected rise, which catches an off-by-one counter. Dropping the request and asserting reset must clear the win in the same half-cycle; a design that only cleared the flag at the next edge would show a stale win there.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned PRIO_W_DEF     = 4;
  localparam int unsigned SETTLE_CYC_DEF = 3;
endpackage

// File: rtl/contend_chain.sv
module contend_chain #(
  parameter int unsigned PRIO_W = arb_pkg::PRIO_W_DEF
) (
  input  logic              req_i,
  input  logic [PRIO_W-1:0] code_i,
  input  logic [PRIO_W-1:0] line_n_i,
  output logic [PRIO_W-1:0] pull_o,
  output logic              alive_o
);
  // stay[n]: board still contends when bit n is decided
  logic [PRIO_W-1:0] stay;

  assign stay[PRIO_W-1] = req_i;

  generate
    for (genvar n = PRIO_W - 1; n > 0; n--) begin : g_link
      assign stay[n-1] = stay[n] & (code_i[n] | line_n_i[n]);
    end
    for (genvar n = 0; n < PRIO_W; n++) begin : g_drv
      assign pull_o[n] = stay[n] & code_i[n];
    end
  endgenerate

  assign alive_o = stay[0] & (code_i[0] | line_n_i[0]);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_CYC = arb_pkg::SETTLE_CYC_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic ready_o
);
  localparam int unsigned CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !req_i) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready_o = req_i && (cnt == LIMIT);
endmodule

// File: rtl/prio_contender.sv
module prio_contender #(
  parameter int unsigned PRIO_W     = arb_pkg::PRIO_W_DEF,
  parameter int unsigned SETTLE_CYC = arb_pkg::SETTLE_CYC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [PRIO_W-1:0] code_i,
  input  logic [PRIO_W-1:0] line_n_i,
  output logic [PRIO_W-1:0] pull_o,
  output logic              win_o
);
  logic alive;
  logic ready;
  logic win_q;

  contend_chain #(.PRIO_W(PRIO_W)) u_chain (
    .req_i    (req_i),
    .code_i   (code_i),
    .line_n_i (line_n_i),
    .pull_o   (pull_o),
    .alive_o  (alive)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .ready_o (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= ready & alive;
  end

  assign win_o = win_q & req_i & ~rst;

  // Checks
  assert_pull_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (pull_o != '0) |-> req_i);

  assert_win_covers_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(win_o) |-> $past(&(code_i | line_n_i)));

  assert_settle_R8: assert property (@(posedge clk) disable iff (rst)
    win_o |-> $past(req_i));

  generate
    for (genvar k = 1; k < PRIO_W; k++) begin : g_chk
      assert_withdraw_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i && !line_n_i[k] && !code_i[k]) |-> (pull_o[k-1:0] == '0));
    end
  endgenerate
endmodule

// File: tb/sim_prio_contender.sv
`timescale 1ns/1ps
module sim_prio_contender;
  localparam int W  = 4;
  localparam int NB = 4;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NB-1:0]   req;
  logic [NB*W-1:0] codes;
  logic [NB*W-1:0] pulls;
  logic [NB-1:0]   win;
  logic [W-1:0]    line_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // wired-AND bus: a line is low when any board pulls it
  always_comb begin
    line_n = '1;
    for (int b = 0; b < NB; b++) line_n = line_n & ~pulls[b*W +: W];
  end

  prio_contender #(.PRIO_W(W), .SETTLE_CYC(SC)) u0 (
    .clk(clk), .rst(rst), .req_i(req[0]), .code_i(codes[W-1:0]),
    .line_n_i(line_n), .pull_o(pulls[W-1:0]), .win_o(win[0]));

  generate
    for (genvar i = 1; i < NB; i++) begin : g_brd
      prio_contender #(.PRIO_W(W), .SETTLE_CYC(SC)) u_arb (
        .clk(clk), .rst(rst), .req_i(req[i]), .code_i(codes[i*W +: W]),
        .line_n_i(line_n), .pull_o(pulls[i*W +: W]), .win_o(win[i]));
    end
  endgenerate

  // reference: resolve bit by bit from MSB
  function automatic logic [NB-1:0] ref_win(logic [NB-1:0] r, logic [NB*W-1:0] c,
                                            output logic [W-1:0] asserted);
    logic [NB-1:0] alive = r;
    asserted = '0;
    for (int n = W - 1; n >= 0; n--) begin
      for (int b = 0; b < NB; b++)
        if (alive[b] && c[b*W + n]) asserted[n] = 1'b1;
      if (asserted[n])
        for (int b = 0; b < NB; b++)
          if (!c[b*W + n]) alive[b] = 1'b0;
    end
    return alive;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req = '0;
    tick(2);
  endtask

  task automatic trial(logic [NB-1:0] r, logic [NB*W-1:0] c, string tag);
    logic [NB-1:0] ew;
    logic [W-1:0]  el;
    idle();
    codes = c;
    req   = r;
    ew = ref_win(r, c, el);
    #0.5;
    chk(~line_n == el, {tag, " lines R5"}, ~line_n, el);
    tick(SC + 1);
    chk(win == ew, {tag, " win R6"}, win, ew);
  endtask

  initial begin
    logic [W-1:0] dummy;
    req = '0; codes = '0;
    tick(3);
    chk(win == '0, "reset win R9", win, 0);
    chk(pulls == '0, "reset pulls R3", pulls, 0);
    // reset with request: win must stay low
    codes = {NB{4'hF}};
    req = 4'b0001;
    tick(SC + 2);
    chk(win[0] == 1'b0, "req during reset R9", win[0], 0);
    rst = 1'b0;
    idle();

    // R8 settle window and R7 lone requester with code 0
    codes = '0;
    req = 4'b0001;
    tick(SC);
    chk(win[0] == 1'b0, "early win R8", win[0], 0);
    chk(pulls[W-1:0] == '0, "code0 no pull R2", pulls[W-1:0], 0);
    tick(1);
    chk(win[0] == 1'b1, "settled win R8 R7", win[0], 1);
    // R9 drop request, same half-cycle
    req = 4'b0000;
    #0.5;
    chk(win[0] == 1'b0, "drop req R9", win[0], 0);
    chk(pulls == '0, "no req no pull R3", pulls, 0);
    // reset while winning
    req = 4'b0001;
    tick(SC + 2);
    rst = 1'b1;
    #0.5;
    chk(win[0] == 1'b0, "reset clears R9", win[0], 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 top line, R4 withdrawal: board0=1000, board1=0111
    idle();
    codes = {4'h0, 4'h0, 4'h7, 4'h8};
    req = 4'b0011;
    #0.5;
    chk(pulls[W-1:0] == 4'h8, "top pull R2", pulls[W-1:0], 4'h8);
    chk(pulls[2*W-1:W] == 4'h0, "loser withdraws R4", pulls[2*W-1:W], 0);
    chk(line_n == 4'h7, "bus lines R1", line_n, 4'h7);
    tick(SC + 1);
    chk(win == 4'b0001, "msb decides R6", win, 4'b0001);

    // codes differing only in bit 0
    trial(4'b0110, {4'h0, 4'hA, 4'hB, 4'h0}, "lsb diff");
    // tie
    trial(4'b1010, {4'h5, 4'h2, 4'h5, 4'h1}, "tie R10");
    chk(win == 4'b1010, "tie both win R10", win, 4'b1010);
    // code zero against others
    trial(4'b1001, {4'h1, 4'h0, 4'h0, 4'h0}, "zero loses");

    // random mix
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      logic [NB-1:0] r = NB'($urandom);
      logic [NB*W-1:0] c = (NB*W)'($urandom);
      trial(r, c, "random");
    end
    dummy = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule